// File: doc/BRIEF.md
# EEPROM Page Buffer and Program Sequencer

This block sits behind a serial-bus slave engine in a small EEPROM. The slave engine hands it a starting memory address, then the data bytes of a write transfer one by one, and finally a pulse when the bus STOP is seen. The block keeps the bytes in a small page buffer. On STOP it runs a self-timed program sequence that writes the buffered bytes into the memory array one at a time, holding each byte on the array write port for a fixed number of clock cycles. While it runs, it raises a busy flag toward the slave engine.

The page size is a parameter of 2 or 8 bytes, and it selects the overflow rule. In the 2-byte mode, a byte beyond the page is refused: the block raises a not-acknowledge request and drops the whole transfer, so nothing is programmed. In the 8-byte mode, extra bytes wrap around inside the page and overwrite earlier slots. Only the low address bits step, so the write never leaves the page. The program time is the number of distinct bytes held, times the per-byte delay.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, `busy`, `mem_we` and `nack_req` are low.
- R2: An address load, one data byte and a STOP program exactly one location: the loaded address with that byte.
- R3: With N bytes (1 ≤ N ≤ page size), the block writes N locations in the order the bytes arrived. Location k is the start address with its low log2(page size) bits increased by k modulo the page size; the upper address bits stay fixed.
- R4: `busy` rises in the cycle after the clock edge that samples STOP and stays high for exactly N × `PROG_CYCLES` cycles. Counting the first busy cycle as 0, the k-th write strobe (k from 0) is a single-cycle `mem_we` in busy cycle k × `PROG_CYCLES` + `PROG_CYCLES` − 1. Address and data are stable while a byte is held.
- R5: In the 8-byte mode, more than 8 bytes never raise `nack_req`. Each of the 8 slots is programmed once, holding the last byte that was received for it. N is 8.
- R6: In the 2-byte mode, a third data byte raises `nack_req` in the same cycle as its `byte_valid`. Every later byte also raises `nack_req` until the next address load, and a STOP then programs nothing.
- R7: A STOP with no data bytes pending does not raise `busy`.
- R8: While `busy` is high, `addr_load`, `byte_valid` and `stop_pulse` have no effect and `nack_req` stays low.
- R9: An address load while idle discards any pending bytes and clears an aborted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Start a new transfer at `addr_in` |
| addr_in | input | ADDR_W | Start address of the transfer |
| byte_valid | input | 1 | One data byte is offered on `byte_data` |
| byte_data | input | 8 | Data byte |
| stop_pulse | input | 1 | Bus STOP detected |
| nack_req | output | 1 | Refuse the byte offered this cycle (combinational) |
| busy | output | 1 | Program sequence is running |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
`nack_req` is combinational, so it is due in the same cycle as the offending byte. The bench samples it 1 ns after it drives `byte_valid` on a falling edge. `busy` and `mem_we` come only from registers. The bench samples them on every falling edge and counts busy cycles from the first falling edge after the STOP edge. With that count it checks that busy lasts N × `PROG_CYCLES` cycles and that strobe k falls in busy cycle k × `PROG_CYCLES` + `PROG_CYCLES` − 1. For the zero-byte STOP and the inputs sent while busy, the bench first waits a fixed window of cycles. It then confirms the result through later writes on the array port.

// File: rtl/eeprom_pp_pkg.sv
// Shared definitions for the EEPROM page buffer and program sequencer.
package eeprom_pp_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] data_t;
    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/epp_fill_ctrl.sv
// Fill control: tracks how many bytes the page holds, the next slot to
// write and whether the transfer was aborted. Decides refusal (nack) and
// program start. Input priority while idle: address load, then byte,
// then STOP. Assumes PAGE_BYTES is a power of two. All inputs are
// ignored while busy.
module epp_fill_ctrl #(
    parameter int PAGE_BYTES   = 8,
    parameter int IDX_W        = 3,
    parameter int CNT_W        = 4,
    parameter bit WRAP_ON_FULL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             addr_load,
    input  logic             byte_valid,
    input  logic             stop_pulse,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             nack_req,
    output logic             prog_start
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] ptr_q;
    logic             aborted_q;
    logic             full;
    logic             refuse;
    logic             take_byte;

    // Refusal and acceptance decisions for the byte offered this cycle.
    always_comb begin
        full       = (cnt_q == CNT_FULL);
        refuse     = aborted_q || (full && !WRAP_ON_FULL);
        take_byte  = byte_valid && !busy && !addr_load;
        nack_req   = take_byte && refuse;
        wr_en      = take_byte && !refuse;
        prog_start = stop_pulse && !busy && !addr_load && !byte_valid
                     && (cnt_q != '0) && !aborted_q;
    end

    assign wr_idx   = ptr_q;
    assign fill_cnt = cnt_q;

    // Fill count, slot pointer and abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ptr_q     <= '0;
            aborted_q <= 1'b0;
        end else if (!busy) begin
            if (addr_load) begin
                cnt_q     <= '0;
                ptr_q     <= '0;
                aborted_q <= 1'b0;
            end else if (byte_valid) begin
                if (refuse) begin
                    aborted_q <= 1'b1;
                    cnt_q     <= '0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                    if (!full) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else if (stop_pulse) begin
                cnt_q     <= '0;
                ptr_q     <= '0;
                aborted_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/epp_page_buffer.sv
// Page buffer: one register per slot, written by slot index and read
// combinationally. Holds data only, so it has no reset.
module epp_page_buffer
    import eeprom_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  data_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output data_t            rd_data
);
    data_t slot_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Capture the byte addressed to this slot.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/epp_prog_seq.sv
// Program sequencer: after a start pulse, steps through fill_cnt slots.
// It holds each slot for PROG_CYCLES cycles and strobes the write in the
// last of them. Assumes fill_cnt is nonzero at start and PROG_CYCLES >= 1.
module epp_prog_seq
    import eeprom_pp_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int CNT_W       = 4,
    parameter int PROG_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             busy,
    output logic [IDX_W-1:0] rd_idx,
    output logic             mem_we
);
    localparam int TMR_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PROG_CYCLES - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] last_q;
    logic [TMR_W-1:0] tmr_q;

    // Sequence state, slot index and per-byte timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            tmr_q   <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (prog_start) begin
                state_q <= SEQ_RUN;
                idx_q   <= '0;
                last_q  <= fill_cnt - 1'b1;
                tmr_q   <= '0;
            end
        end else if (tmr_q == TMR_LAST) begin
            tmr_q <= '0;
            if (idx_q == last_q) begin
                state_q <= SEQ_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign busy   = (state_q == SEQ_RUN);
    assign mem_we = busy && (tmr_q == TMR_LAST);
    assign rd_idx = idx_q[IDX_W-1:0];
endmodule

// File: rtl/eeprom_page_prog.sv
// Top level: page buffer and self-timed program sequencer behind a
// serial-bus slave engine. Latches the start address, buffers up to
// PAGE_BYTES bytes, and programs them on STOP. The page is 2 bytes
// (overflow aborts) or 8 bytes (overflow wraps). Assumes ADDR_W exceeds
// log2(PAGE_BYTES).
module eeprom_page_prog
    import eeprom_pp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_pulse,
    output logic              nack_req,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int IDX_W        = $clog2(PAGE_BYTES);
    localparam int CNT_W        = IDX_W + 1;
    localparam bit WRAP_ON_FULL = (PAGE_BYTES > 2);

    logic [ADDR_W-1:0] base_q;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  fill_cnt;
    logic              prog_start;
    logic [IDX_W-1:0]  rd_idx;
    data_t             rd_data;
    logic [IDX_W-1:0]  low_addr;

    // Start address register, loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (addr_load && !busy) begin
            base_q <= addr_in;
        end
    end

    epp_fill_ctrl #(
        .PAGE_BYTES  (PAGE_BYTES),
        .IDX_W       (IDX_W),
        .CNT_W       (CNT_W),
        .WRAP_ON_FULL(WRAP_ON_FULL)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .addr_load (addr_load),
        .byte_valid(byte_valid),
        .stop_pulse(stop_pulse),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .fill_cnt  (fill_cnt),
        .nack_req  (nack_req),
        .prog_start(prog_start)
    );

    epp_page_buffer #(
        .PAGE_BYTES(PAGE_BYTES),
        .IDX_W     (IDX_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(byte_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    epp_prog_seq #(
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_start(prog_start),
        .fill_cnt  (fill_cnt),
        .busy      (busy),
        .rd_idx    (rd_idx),
        .mem_we    (mem_we)
    );

    // Only the low address bits step; the page bits stay fixed.
    assign low_addr  = base_q[IDX_W-1:0] + rd_idx;
    assign mem_addr  = {base_q[ADDR_W-1:IDX_W], low_addr};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/epp_checker.sv
// Checker for eeprom_page_prog. It watches the port-level timing of the
// program sequence and the refusal rules, and is bound to every instance.
module epp_checker #(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              stop_pulse,
    input logic              nack_req,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && PROG_CYCLES > 1) |=> !mem_we);

    p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> (busy && $stable(mem_addr) && $stable(mem_wdata)));

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mem_addr[ADDR_W-1:IDX_W])));

    p_start_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse));

    p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |-> (!busy && byte_valid));

    p_wide_no_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |-> (PAGE_BYTES == 2));
endmodule

bind eeprom_page_prog epp_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_valid(byte_valid),
    .stop_pulse(stop_pulse),
    .nack_req  (nack_req),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_eeprom_page_prog.sv
`timescale 1ns/1ps
// Bench: u0 uses 8-byte pages, u1 uses 2-byte pages; both share stimulus.
module sim_eeprom_page_prog;
    localparam int AW   = 9;
    localparam int PROG = 4;

    typedef struct packed {
        logic [8:0] addr;
        logic [7:0] n;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{9'h000, 8'd1,  8'h11},
        '{9'h0A3, 8'd2,  8'h20},
        '{9'h105, 8'd5,  8'h40},
        '{9'h1FE, 8'd8,  8'h60},
        '{9'h0F6, 8'd10, 8'h80},
        '{9'h03A, 8'd3,  8'hC0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop_pulse = 1'b0;
    logic          nack0, busy0, we0, nack1, busy1, we1;
    logic [AW-1:0] maddr0, maddr1;
    logic [7:0]    mdata0, mdata1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Monitor records
    logic [AW-1:0] w0_addr [16];
    logic [7:0]    w0_data [16];
    int            w0_at   [16];
    int            w0_n, bc0;
    logic [AW-1:0] w1_addr [16];
    logic [7:0]    w1_data [16];
    int            w1_at   [16];
    int            w1_n, bc1;
    int            nk0, nk1;

    always #2 clk = ~clk;

    eeprom_page_prog #(.ADDR_W(AW), .PAGE_BYTES(8), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .nack_req(nack0), .busy(busy0), .mem_we(we0), .mem_addr(maddr0),
        .mem_wdata(mdata0));

    eeprom_page_prog #(.ADDR_W(AW), .PAGE_BYTES(2), .PROG_CYCLES(PROG)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .nack_req(nack1), .busy(busy1), .mem_we(we1), .mem_addr(maddr1),
        .mem_wdata(mdata1));

    // Record busy cycles and write strobes away from the active edge.
    always @(negedge clk) begin
        if (busy0) begin
            if (we0 && w0_n < 16) begin
                w0_addr[w0_n] = maddr0;
                w0_data[w0_n] = mdata0;
                w0_at[w0_n]   = bc0;
                w0_n++;
            end
            bc0++;
        end
        if (busy1) begin
            if (we1 && w1_n < 16) begin
                w1_addr[w1_n] = maddr1;
                w1_data[w1_n] = mdata1;
                w1_at[w1_n]   = bc1;
                w1_n++;
            end
            bc1++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        w0_n = 0; bc0 = 0; w1_n = 0; bc1 = 0; nk0 = 0; nk1 = 0;
    endtask

    task automatic load(input logic [AW-1:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        #1;
        if (nack0) nk0++;
        if (nack1) nk1++;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy0 && !busy1) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // Compare u0 records against the wide-page model (R3, R4, R5).
    task automatic check_wide(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                              input string req);
        int slots;
        slots = (n > 8) ? 8 : n;
        chk(w0_n == slots, req, "u0 write count", w0_n, slots);
        chk(bc0 == slots * PROG, "R4", "u0 busy cycles", bc0, slots * PROG);
        chk(nk0 == 0, "R5", "u0 nack count", nk0, 0);
        for (int k = 0; k < slots && k < w0_n; k++) begin
            logic [AW-1:0] ea;
            logic [7:0]    ed;
            int            last;
            last = k + 8 * ((n - 1 - k) / 8);
            ea = {a[AW-1:3], 3'(a[2:0] + 3'(k))};
            ed = 8'(seed + 8'(last));
            chk(w0_addr[k] == ea, req, "u0 write addr", w0_addr[k], ea);
            chk(w0_data[k] == ed, req, "u0 write data", w0_data[k], ed);
            chk(w0_at[k] == k * PROG + PROG - 1, "R4", "u0 strobe cycle",
                w0_at[k], k * PROG + PROG - 1);
        end
    endtask

    // Compare u1 records against the narrow-page model (R3, R4, R6).
    task automatic check_narrow(input logic [AW-1:0] a, input int n, input logic [7:0] seed);
        int exp_n;
        exp_n = (n > 2) ? 0 : n;
        chk(w1_n == exp_n, (n > 2) ? "R6" : "R3", "u1 write count", w1_n, exp_n);
        chk(bc1 == exp_n * PROG, "R4", "u1 busy cycles", bc1, exp_n * PROG);
        chk(nk1 == ((n > 2) ? n - 2 : 0), "R6", "u1 nack count", nk1, (n > 2) ? n - 2 : 0);
        for (int k = 0; k < exp_n && k < w1_n; k++) begin
            logic [AW-1:0] ea;
            ea = {a[AW-1:1], 1'(a[0] + 1'(k))};
            chk(w1_addr[k] == ea, "R3", "u1 write addr", w1_addr[k], ea);
            chk(w1_data[k] == 8'(seed + 8'(k)), "R3", "u1 write data",
                w1_data[k], 8'(seed + 8'(k)));
            chk(w1_at[k] == k * PROG + PROG - 1, "R4", "u1 strobe cycle",
                w1_at[k], k * PROG + PROG - 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy0 && !busy1, "R1", "busy after reset", {busy1, busy0}, 0);
        chk(!we0 && !we1, "R1", "mem_we after reset", {we1, we0}, 0);
        chk(!nack0 && !nack1, "R1", "nack_req after reset", {nack1, nack0}, 0);

        // Table walk: R2 (n=1), R3 pages, R5 wrap, R6 narrow abort
        for (int v = 0; v < 6; v++) begin
            clear_mon();
            load(VEC[v].addr);
            for (int i = 0; i < int'(VEC[v].n); i++) send(8'(VEC[v].seed + 8'(i)));
            stop();
            wait_idle();
            check_wide(VEC[v].addr, int'(VEC[v].n), VEC[v].seed,
                       (VEC[v].n == 1) ? "R2" : ((VEC[v].n > 8) ? "R5" : "R3"));
            check_narrow(VEC[v].addr, int'(VEC[v].n), VEC[v].seed);
        end

        // R7: STOP with nothing pending
        clear_mon();
        stop();
        repeat (10) @(negedge clk);
        chk(bc0 == 0 && bc1 == 0, "R7", "busy on empty STOP", bc0 + bc1, 0);

        // R8: inputs while busy are ignored
        clear_mon();
        load(9'h040);
        send(8'hA1);
        send(8'hA2);
        stop();
        load(9'h1F0);
        send(8'h55);
        chk(nk0 == 0 && nk1 == 0, "R8", "nack while busy", nk0 + nk1, 0);
        stop();
        wait_idle();
        chk(w0_n == 2 && w1_n == 2, "R8", "write count with busy inputs", w0_n, 2);
        chk(w0_data[1] == 8'hA2 && w1_data[1] == 8'hA2, "R8", "data with busy inputs",
            w0_data[1], 8'hA2);
        clear_mon();
        stop();
        repeat (10) @(negedge clk);
        chk(bc0 == 0 && bc1 == 0, "R8", "byte sent while busy was kept", bc0 + bc1, 0);
        clear_mon();
        send(8'h3C);
        stop();
        wait_idle();
        chk(w0_n == 1 && w0_addr[0] == 9'h040, "R8", "address load while busy took effect",
            w0_addr[0], 9'h040);
        chk(w1_n == 1 && w1_addr[0] == 9'h040, "R8", "u1 address after busy load",
            w1_addr[0], 9'h040);

        // R6: bytes after abort keep nacking; STOP programs nothing in u1
        clear_mon();
        load(9'h010);
        send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        chk(nk1 == 2, "R6", "u1 nacks after abort", nk1, 2);
        stop();
        wait_idle();
        chk(w1_n == 0 && bc1 == 0, "R6", "u1 programmed after abort", w1_n, 0);
        chk(w0_n == 4, "R3", "u0 writes alongside abort", w0_n, 4);

        // R9: address load clears abort and pending bytes
        clear_mon();
        load(9'h010);
        send(8'h01); send(8'h02); send(8'h03);
        load(9'h012);
        send(8'h77);
        stop();
        wait_idle();
        chk(w1_n == 1 && w1_addr[0] == 9'h012, "R9", "u1 write addr after reload",
            w1_addr[0], 9'h012);
        chk(w1_data[0] == 8'h77, "R9", "u1 write data after reload", w1_data[0], 8'h77);
        chk(w0_n == 1 && w0_addr[0] == 9'h012 && w0_data[0] == 8'h77, "R9",
            "u0 pending bytes discarded", w0_n, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule